// File: doc/BRIEF.md
# Single-Adder Arithmetic Unit

This combinational block performs eight arithmetic operations with one W-bit adder. Operand A always enters the adder unchanged. Operand B first passes through a conditioning stage that a 2-bit code controls. That stage forwards B, its bitwise complement, all zeros or all ones. The adder's carry-in comes from a separate input. The 2-bit code and the carry-in together give add, add with carry, subtract, subtract-minus-one, transfer, increment, decrement and a second transfer form.

The block provides the carry out of the most significant bit. It also provides, as a separate output, the carry that enters the most significant bit. A downstream flag stage can form signed overflow as the XOR of these two carries, so the unit itself holds no state and keeps no flags. Outputs follow the inputs within the same cycle.

Top module: `arith_core`

## Requirements
- R1: When bmode=00 (B passed through), {carry_out, sum} equals A + B + cin computed at W+1 bits.
- R2: When bmode=01 (B complemented) and cin=1, sum equals A − B modulo 2^W, and carry_out is 1 exactly when A ≥ B unsigned.
- R3: When bmode=01 and cin=0, sum equals A + ~B, which is A − B − 1 modulo 2^W, and carry_out is 1 exactly when A > B unsigned.
- R4: When bmode=10 (zeros) and cin=0, sum equals A and carry_out is 0, whatever the value of B.
- R5: When bmode=10 and cin=1, sum equals A + 1 modulo 2^W, and carry_out is 1 only when A is all ones.
- R6: When bmode=11 (ones) and cin=0, sum equals A − 1 modulo 2^W, and carry_out is 1 exactly when A ≠ 0.
- R7: When bmode=11 and cin=1, sum equals A and carry_out is 1, whatever the value of B.
- R8: carry_msb is the carry into bit W−1, so carry_msb XOR carry_out is 1 exactly when the operation overflows as a signed two's-complement operation.
- R9: The block is purely combinational. Outputs reflect new inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | First operand, fed to the adder unchanged |
| opb | input | W | Second operand, conditioned before the adder |
| bmode | input | 2 | B conditioning code: 00 B, 01 ~B, 10 zeros, 11 ones |
| cin | input | 1 | Adder carry-in |
| sum | output | W | Adder result |
| carry_out | output | 1 | Carry out of bit W−1 |
| carry_msb | output | 1 | Carry into bit W−1 |

## Verification
The bound checker re-evaluates the arithmetic identity for every bmode and cin pair each time an input changes. These identities are the W+1-bit add, the subtraction and its unsigned-compare carry, increment, decrement and both transfer forms. It also checks the carry into the MSB against an independent narrow sum when B is passed through or zeroed. Only the bench scenarios show that signed overflow, derived from the two carries, matches hand-computed values at the boundaries. The same applies to B being ignored in the zero and ones modes, and to outputs settling with no clock edge.

// File: rtl/arith_core.sv
module arith_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   bmode,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         carry_msb
);
  localparam logic [1:0] M_PASS = 2'b00;
  localparam logic [1:0] M_INV  = 2'b01;
  localparam logic [1:0] M_ZERO = 2'b10;
  localparam logic [1:0] M_ONES = 2'b11;

  logic [W-1:0] bq;
  logic [W-1:0] low;

  always_comb begin
    unique case (bmode)
      M_PASS:  bq = opb;
      M_INV:   bq = ~opb;
      M_ZERO:  bq = '0;
      M_ONES:  bq = '1;
      default: bq = opb;
    endcase
  end

  // low part: W-1 data bits plus the carry into the MSB
  assign low = {1'b0, opa[W-2:0]} + {1'b0, bq[W-2:0]} + {{(W-1){1'b0}}, cin};

  assign carry_msb = low[W-1];
  assign sum       = {opa[W-1] ^ bq[W-1] ^ carry_msb, low[W-2:0]};
  assign carry_out = (opa[W-1] & bq[W-1]) | (carry_msb & (opa[W-1] ^ bq[W-1]));
endmodule

module arith_core_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [1:0]   bmode,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         carry_out,
  input logic         carry_msb
);
  logic [W:0]   wide;
  logic [W-1:0] nar;

  assign wide = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
  assign nar  = {1'b0, opa[W-2:0]}
              + ((bmode == 2'b00) ? {1'b0, opb[W-2:0]} : '0)
              + {{(W-1){1'b0}}, cin};

  always_comb begin
    if (bmode == 2'b00)
      a_r1_add: assert ({carry_out, sum} == wide) else $error("R1 add mismatch");
    if (bmode == 2'b01 && cin)
      a_r2_sub: assert (sum == opa - opb && carry_out == (opa >= opb)) else $error("R2 sub mismatch");
    if (bmode == 2'b01 && !cin)
      a_r3_subm1: assert (sum == opa - opb - 1'b1 && carry_out == (opa > opb)) else $error("R3 mismatch");
    if (bmode == 2'b10 && !cin)
      a_r4_xfer: assert (sum == opa && !carry_out) else $error("R4 transfer mismatch");
    if (bmode == 2'b10 && cin)
      a_r5_inc: assert (sum == opa + 1'b1 && carry_out == (&opa)) else $error("R5 inc mismatch");
    if (bmode == 2'b11 && !cin)
      a_r6_dec: assert (sum == opa - 1'b1 && carry_out == (|opa)) else $error("R6 dec mismatch");
    if (bmode == 2'b11 && cin)
      a_r7_xfer1: assert (sum == opa && carry_out) else $error("R7 mismatch");
    if (!bmode[0])
      a_r8_cmsb: assert (carry_msb == nar[W-1]) else $error("R8 msb carry mismatch");
  end
endmodule

bind arith_core arith_core_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .bmode(bmode), .cin(cin),
  .sum(sum), .carry_out(carry_out), .carry_msb(carry_msb)
);

// File: tb/sim_arith_core.sv
module sim_arith_core;
  localparam int  W = 32;
  localparam time PERIOD = 10;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0]  m;
    logic        c;
    logic [31:0] r;
    logic        co;
    logic        ov;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{32'h5,        32'h3,        2'd0, 1'b0, 32'h8,        1'b0, 1'b0}, // R1
    '{32'h5,        32'h3,        2'd0, 1'b1, 32'h9,        1'b0, 1'b0}, // R1
    '{32'hFFFFFFFF, 32'h1,        2'd0, 1'b0, 32'h0,        1'b1, 1'b0}, // R1
    '{32'h7FFFFFFF, 32'h1,        2'd0, 1'b0, 32'h80000000, 1'b0, 1'b1}, // R1 R8
    '{32'hA,        32'h3,        2'd1, 1'b1, 32'h7,        1'b1, 1'b0}, // R2
    '{32'h3,        32'hA,        2'd1, 1'b1, 32'hFFFFFFF9, 1'b0, 1'b0}, // R2
    '{32'h80000000, 32'h1,        2'd1, 1'b1, 32'h7FFFFFFF, 1'b1, 1'b1}, // R2 R8
    '{32'hA,        32'h3,        2'd1, 1'b0, 32'h6,        1'b1, 1'b0}, // R3
    '{32'h3,        32'h3,        2'd1, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0}, // R3
    '{32'hDEADBEEF, 32'h12345678, 2'd2, 1'b0, 32'hDEADBEEF, 1'b0, 1'b0}, // R4
    '{32'hFFFFFFFF, 32'h55555555, 2'd2, 1'b1, 32'h0,        1'b1, 1'b0}, // R5
    '{32'h7FFFFFFF, 32'h0,        2'd2, 1'b1, 32'h80000000, 1'b0, 1'b1}, // R5 R8
    '{32'h0,        32'h0,        2'd3, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0}, // R6
    '{32'h80000000, 32'h0,        2'd3, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b1}, // R6 R8
    '{32'h1234,     32'hFFFF,     2'd3, 1'b1, 32'h1234,     1'b1, 1'b0}  // R7
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opa = '0, opb = '0, sum;
  logic [1:0]   bmode = 2'b00;
  logic         cin = 1'b0, carry_out, carry_msb;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  arith_core #(.W(W)) u0 (
    .opa(opa), .opb(opb), .bmode(bmode), .cin(cin),
    .sum(sum), .carry_out(carry_out), .carry_msb(carry_msb)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] m, input logic c);
    @(negedge clk);
    opa = a; opb = b; bmode = m; cin = c;
    #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk("reset R1 sum", sum, '0);
    chk("reset R1 carry", {31'b0, carry_out}, 32'b0);
    repeat (2) @(posedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].a, TBL[i].b, TBL[i].m, TBL[i].c);
      chk($sformatf("R1-7 vec%0d sum", i), sum, TBL[i].r);
      chk($sformatf("R1-7 vec%0d carry", i), {31'b0, carry_out}, {31'b0, TBL[i].co});
      chk($sformatf("R8 vec%0d ovf", i), {31'b0, carry_out ^ carry_msb}, {31'b0, TBL[i].ov});
    end

    // R4 / R7: B has no effect in zero and ones modes
    drive(32'hCAFEF00D, 32'h0, 2'd2, 1'b0);
    drive(32'hCAFEF00D, 32'hFFFFFFFF, 2'd2, 1'b0);
    chk("R4 B ignored", sum, 32'hCAFEF00D);
    drive(32'hCAFEF00D, 32'h0F0F0F0F, 2'd3, 1'b1);
    chk("R7 B ignored", sum, 32'hCAFEF00D);
    chk("R7 carry", {31'b0, carry_out}, 32'h1);

    // R9: change inputs with no clock edge in between
    @(negedge clk);
    opa = 32'h100; opb = 32'h23; bmode = 2'd0; cin = 1'b0;
    #1 chk("R9 settle a", sum, 32'h123);
    opb = 32'h1;
    #1 chk("R9 settle b", sum, 32'h101);

    // R1 / R2 sweep with independently computed references
    begin
      logic [W-1:0] x, y;
      logic [W:0] w;
      x = 32'h13579BDF; y = 32'h2468ACE0;
      for (int k = 0; k < 16; k++) begin
        x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
        y = y * 32'd1103515245 + 32'd12345;
        drive(x, y, 2'd0, k[0]);
        w = {1'b0, x} + {1'b0, y} + {32'b0, k[0]};
        chk("R1 sweep sum", sum, w[W-1:0]);
        chk("R1 sweep carry", {31'b0, carry_out}, {31'b0, w[W]});
        drive(x, y, 2'd1, 1'b1);
        chk("R2 sweep sum", sum, x - y);
        chk("R2 sweep carry", {31'b0, carry_out}, {31'b0, x >= y});
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule